// File: doc/BRIEF.md
# Shifter Operand Unit with Carry-Out

This block forms the second ALU operand from a 32-bit register value and computes the carry bit that the shift produces. Each cycle it takes the operand, a shift kind and a shift amount, the current carry flag, an operation class and a set-flags bit. One clock edge later it presents four outputs:

- the shifted value;
- the shifter carry, which is the last bit that left the operand;
- an enable that tells the flag logic whether to write that carry;
- an illegal-encoding indicator.

The shift kinds are logical left, logical right, arithmetic right, rotate right, and a one-bit rotate right through the carry flag. Whether the carry flag is written depends on the operation class, not only on the shift. Logical-class operations write it only when their set-flags bit is high. Test-class operations always write it. All other classes never write it. Shift encodings outside the legal ranges are not executed: the operand and the incoming carry pass through, and the error output is raised.

The outputs are registered. The unit therefore takes one pipeline slot, and everything is computed from the inputs sampled at the preceding edge.

Top module: `shop_unit`

## Requirements
- R1: Shift kind code 0 (logical left) by n in 1..31 gives operand shifted left with zeros entering; carry is operand bit 32-n.
- R2: Kind code 1 (logical right) by n in 1..32 gives operand shifted right with zeros entering; carry is operand bit n-1. At n=32 the result is zero and the carry is operand bit 31.
- R3: Kind code 2 (arithmetic right) by n in 1..32 fills the vacated bits with operand bit 31; carry is operand bit n-1. At n=32 every result bit and the carry equal operand bit 31. A shift by 5 therefore equals a signed divide by 32 rounded toward minus infinity.
- R4: Kind code 3 (rotate right) by n in 1..31 rotates the operand; carry is operand bit n-1, which equals result bit 31.
- R5: Amount 0 with kind code 0, 1, 2 or 3 returns the operand unchanged, and the carry output equals the incoming carry flag.
- R6: Kind code 4 (rotate right through carry) ignores the amount. The result is the incoming carry in bit 31 above operand bits 31..1, and the carry output is operand bit 0.
- R7: An encoding is illegal when it is kind code 0 or 3 with amount of 32 or more, kind code 1 or 2 with amount above 32, or any kind code 5 to 7. An illegal encoding raises illegal_o, returns the operand unchanged with the incoming carry, and holds flag_we_o low.
- R8: Class code 0 (logical operations: move, move-inverted, and, or, exclusive-or, bit-clear) raises flag_we_o for a legal encoding only when set_flags_i is 1.
- R9: Class code 1 (test and test-equivalence) raises flag_we_o for every legal encoding, whatever set_flags_i is.
- R10: Class codes 2 and 3 (arithmetic and all other operations) never raise flag_we_o.
- R11: While rst_n is low all outputs are 0. Otherwise each output reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opd_i | input | 32 | Register operand |
| kind_i | input | 3 | Shift kind code |
| amt_i | input | 6 | Shift amount |
| carry_i | input | 1 | Current carry flag |
| cls_i | input | 2 | Operation class code |
| set_flags_i | input | 1 | Set-flags bit of the operation |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |
| flag_we_o | output | 1 | Carry flag write enable |
| illegal_o | output | 1 | Illegal shift encoding |

## Verification
The bench builds the unit with its default parameters: a 32-bit operand and a 6-bit amount. The amount field can therefore express every value from 0 to 63, so the bench can drive each range edge and the out-of-range values just past it. That covers the 32-bit logical-right and arithmetic-right cases, left shift and rotate by 32, and amounts well beyond 32. The random kind codes include the three unused codes, and the random class codes cover all four classes with both settings of the set-flags bit.

// File: rtl/shop_pkg.sv
package shop_pkg;

    typedef enum logic [2:0] {
        SHK_LSL = 3'd0,
        SHK_LSR = 3'd1,
        SHK_ASR = 3'd2,
        SHK_ROR = 3'd3,
        SHK_RRX = 3'd4
    } shk_e;

    typedef enum logic [1:0] {
        OPC_LOGIC = 2'd0,
        OPC_TEST  = 2'd1,
        OPC_ARITH = 2'd2,
        OPC_OTHER = 2'd3
    } opc_e;

endpackage

// File: rtl/shop_legal.sv
module shop_legal #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = $clog2(DATA_W) + 1
) (
    input  logic [2:0]       kind,
    input  logic [AMT_W-1:0] amt,
    output logic             legal
);
    import shop_pkg::*;

    localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

    always_comb begin
        case (kind)
            SHK_LSL: legal = (amt < FULL);
            SHK_LSR: legal = (amt <= FULL);
            SHK_ASR: legal = (amt <= FULL);
            SHK_ROR: legal = (amt < FULL);
            SHK_RRX: legal = 1'b1;
            default: legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/shop_barrel.sv
module shop_barrel #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = $clog2(DATA_W) + 1
) (
    input  logic [DATA_W-1:0] opd,
    input  logic [2:0]        kind,
    input  logic [AMT_W-1:0]  amt,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    import shop_pkg::*;

    localparam int EW = DATA_W + 1;
    localparam int RW = 2 * DATA_W;

    logic [EW-1:0] lsl_ext;
    logic [EW-1:0] lsr_ext;
    logic [EW-1:0] asr_ext;
    logic [RW-1:0] ror_ext;

    // Right shifts carry one guard bit below the operand: it receives the
    // last bit shifted out. Left shift uses a guard bit above the operand.
    always_comb begin
        lsl_ext = {1'b0, opd} << amt;
        lsr_ext = {opd, 1'b0} >> amt;
        asr_ext = $signed({opd, 1'b0}) >>> amt;
        ror_ext = {opd, opd} >> amt;
    end

    always_comb begin
        res  = opd;
        cout = cin;
        if (kind == SHK_RRX) begin
            res  = {cin, opd[DATA_W-1:1]};
            cout = opd[0];
        end else if (amt != '0) begin
            case (kind)
                SHK_LSL: begin
                    res  = lsl_ext[DATA_W-1:0];
                    cout = lsl_ext[DATA_W];
                end
                SHK_LSR: begin
                    res  = lsr_ext[EW-1:1];
                    cout = lsr_ext[0];
                end
                SHK_ASR: begin
                    res  = asr_ext[EW-1:1];
                    cout = asr_ext[0];
                end
                SHK_ROR: begin
                    res  = ror_ext[DATA_W-1:0];
                    cout = ror_ext[DATA_W-1];
                end
                default: begin
                    res  = opd;
                    cout = cin;
                end
            endcase
        end
    end

endmodule

// File: rtl/shop_flag_ctl.sv
module shop_flag_ctl (
    input  logic [1:0] cls,
    input  logic       set_flags,
    input  logic       legal,
    output logic       we
);
    import shop_pkg::*;

    always_comb begin
        case (cls)
            OPC_LOGIC: we = legal & set_flags;
            OPC_TEST:  we = legal;
            default:   we = 1'b0;
        endcase
    end

endmodule

// File: rtl/shop_unit.sv
module shop_unit #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = $clog2(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] opd_i,
    input  logic [2:0]        kind_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic              carry_i,
    input  logic [1:0]        cls_i,
    input  logic              set_flags_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o,
    output logic              flag_we_o,
    output logic              illegal_o
);

    logic              legal;
    logic [DATA_W-1:0] sh_res;
    logic              sh_cout;
    logic              we;
    logic [DATA_W-1:0] nxt_res;
    logic              nxt_cout;

    shop_legal #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_legal (
        .kind  (kind_i),
        .amt   (amt_i),
        .legal (legal)
    );

    shop_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_barrel (
        .opd  (opd_i),
        .kind (kind_i),
        .amt  (amt_i),
        .cin  (carry_i),
        .res  (sh_res),
        .cout (sh_cout)
    );

    shop_flag_ctl u_flag (
        .cls       (cls_i),
        .set_flags (set_flags_i),
        .legal     (legal),
        .we        (we)
    );

    // An illegal encoding is not executed: operand and carry pass through.
    always_comb begin
        nxt_res  = legal ? sh_res  : opd_i;
        nxt_cout = legal ? sh_cout : carry_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o  <= '0;
            carry_o   <= 1'b0;
            flag_we_o <= 1'b0;
            illegal_o <= 1'b0;
        end else begin
            result_o  <= nxt_res;
            carry_o   <= nxt_cout;
            flag_we_o <= we;
            illegal_o <= ~legal;
        end
    end

endmodule

// File: rtl/shop_unit_chk.sv
module shop_unit_chk #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = $clog2(DATA_W) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] opd_i,
    input logic [2:0]        kind_i,
    input logic [AMT_W-1:0]  amt_i,
    input logic              carry_i,
    input logic [1:0]        cls_i,
    input logic              set_flags_i,
    input logic [DATA_W-1:0] result_o,
    input logic              carry_o,
    input logic              flag_we_o,
    input logic              illegal_o
);

    localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i < 3'd4 && amt_i == '0) |=>
            (result_o == $past(opd_i) && carry_o == $past(carry_i))); // R5

    AST_RRX_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == 3'd4) |=>
            (result_o == {$past(carry_i), $past(opd_i[DATA_W-1:1])} &&
             carry_o == $past(opd_i[0]))); // R6

    AST_LSR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == 3'd1 && amt_i == FULL) |=>
            (result_o == '0 && carry_o == $past(opd_i[DATA_W-1]))); // R2

    AST_ASR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == 3'd2 && amt_i == FULL) |=>
            (result_o == {DATA_W{$past(opd_i[DATA_W-1])}} &&
             carry_o == $past(opd_i[DATA_W-1]))); // R3

    AST_LSL_FULL_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == 3'd0 && amt_i == FULL) |=> illegal_o); // R7

    AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !flag_we_o); // R7

    AST_ARITH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_i[1]) |=> !flag_we_o); // R10

    AST_TEST_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_i == 2'd1 && kind_i == 3'd4) |=> flag_we_o); // R9

    AST_LOGIC_NEEDS_S: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_i == 2'd0 && !set_flags_i) |=> !flag_we_o); // R8

endmodule

bind shop_unit shop_unit_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .opd_i       (opd_i),
    .kind_i      (kind_i),
    .amt_i       (amt_i),
    .carry_i     (carry_i),
    .cls_i       (cls_i),
    .set_flags_i (set_flags_i),
    .result_o    (result_o),
    .carry_o     (carry_o),
    .flag_we_o   (flag_we_o),
    .illegal_o   (illegal_o)
);

// File: tb/tb_shop_unit.sv
module tb_shop_unit;

    localparam int DATA_W = 32;
    localparam int AMT_W  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] opd_i = '0;
    logic [2:0]        kind_i = '0;
    logic [AMT_W-1:0]  amt_i = '0;
    logic              carry_i = 1'b0;
    logic [1:0]        cls_i = '0;
    logic              set_flags_i = 1'b0;
    logic [DATA_W-1:0] result_o;
    logic              carry_o;
    logic              flag_we_o;
    logic              illegal_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    shop_unit #(.DATA_W(DATA_W), .AMT_W(AMT_W)) dut (
        .clk(clk), .rst_n(rst_n), .opd_i(opd_i), .kind_i(kind_i),
        .amt_i(amt_i), .carry_i(carry_i), .cls_i(cls_i),
        .set_flags_i(set_flags_i), .result_o(result_o), .carry_o(carry_o),
        .flag_we_o(flag_we_o), .illegal_o(illegal_o)
    );

    function automatic bit ref_legal(input logic [2:0] k, input int n);
        case (k)
            3'd0, 3'd3: return n < 32;
            3'd1, 3'd2: return n <= 32;
            3'd4:       return 1'b1;
            default:    return 1'b0;
        endcase
    endfunction

    // Bit-by-bit model of the shift: {carry, result}
    function automatic logic [32:0] ref_shift(input logic [31:0] a, input logic [2:0] k,
                                              input int n, input logic c);
        logic [31:0] r;
        logic        co;
        r  = a;
        co = c;
        if (!ref_legal(k, n)) return {c, a};
        if (k == 3'd4) begin
            for (int i = 0; i < 31; i++) r[i] = a[i+1];
            r[31] = c;
            co = a[0];
        end else if (n != 0) begin
            for (int i = 0; i < 32; i++) begin
                case (k)
                    3'd0: r[i] = (i >= n) ? a[i-n] : 1'b0;
                    3'd1: r[i] = (i + n < 32) ? a[i+n] : 1'b0;
                    3'd2: r[i] = (i + n < 32) ? a[i+n] : a[31];
                    default: r[i] = a[(i + n) % 32];
                endcase
            end
            co = (k == 3'd0) ? a[32-n] : a[n-1];
        end
        return {co, r};
    endfunction

    function automatic bit ref_we(input logic [1:0] cl, input bit s, input bit lg);
        if (!lg) return 1'b0;
        if (cl == 2'd0) return s;
        if (cl == 2'd1) return 1'b1;
        return 1'b0;
    endfunction

    function automatic string data_tag(input logic [2:0] k, input int n);
        if (!ref_legal(k, n)) return "R7";
        if (k == 3'd4) return "R6";
        if (n == 0) return "R5";
        case (k)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            default: return "R4";
        endcase
    endfunction

    function automatic string flag_tag(input logic [1:0] cl, input bit lg);
        if (!lg) return "R7";
        if (cl == 2'd0) return "R8";
        if (cl == 2'd1) return "R9";
        return "R10";
    endfunction

    task automatic apply(input logic [31:0] a, input logic [2:0] k, input int n,
                         input logic c, input logic [1:0] cl, input bit s);
        logic [32:0] exp_sh;
        bit          lg;
        bit          ew;
        string       dt;
        string       ft;
        opd_i = a; kind_i = k; amt_i = AMT_W'(n); carry_i = c;
        cls_i = cl; set_flags_i = s;
        exp_sh = ref_shift(a, k, n, c);
        lg = ref_legal(k, n);
        ew = ref_we(cl, s, lg);
        dt = data_tag(k, n);
        ft = flag_tag(cl, lg);
        @(negedge clk);
        checks++;
        if (result_o !== exp_sh[31:0] || carry_o !== exp_sh[32] || illegal_o !== !lg) begin
            failures++;
            $display("FAIL %s kind=%0d amt=%0d: res=%h c=%b ill=%b expected res=%h c=%b ill=%b",
                     dt, k, n, result_o, carry_o, illegal_o, exp_sh[31:0], exp_sh[32], !lg);
        end
        checks++;
        if (flag_we_o !== ew) begin
            failures++;
            $display("FAIL %s cls=%0d s=%b: we=%b expected we=%b", ft, cl, s, flag_we_o, ew);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        opd_i = 32'hFFFF_FFFF; carry_i = 1'b1; cls_i = 2'd1; kind_i = 3'd4;
        repeat (3) @(negedge clk);
        // R11: reset state
        checks++;
        if (result_o !== '0 || carry_o !== 1'b0 || flag_we_o !== 1'b0 || illegal_o !== 1'b0) begin
            failures++;
            $display("FAIL R11 reset: res=%h c=%b we=%b ill=%b expected all zero",
                     result_o, carry_o, flag_we_o, illegal_o);
        end
        rst_n = 1'b1;

        // Directed corners
        apply(32'h8000_0001, 3'd0, 1, 1'b0, 2'd0, 1'b1);   // R1
        apply(32'h0000_0001, 3'd0, 31, 1'b0, 2'd1, 1'b0);  // R1
        apply(32'h8000_0000, 3'd1, 32, 1'b0, 2'd1, 1'b0);  // R2 LSR 32
        apply(32'h7FFF_FFFF, 3'd1, 32, 1'b1, 2'd0, 1'b1);  // R2
        apply(32'h8000_0000, 3'd2, 32, 1'b0, 2'd0, 1'b1);  // R3 ASR 32
        apply(32'hFFFF_FFC1, 3'd2, 5, 1'b0, 2'd2, 1'b1);   // R3 -63/32 -> -2
        apply(32'h0000_0011, 3'd3, 4, 1'b0, 2'd1, 1'b1);   // R4
        apply(32'h0000_0010, 3'd3, 31, 1'b1, 2'd0, 1'b0);  // R4 R8
        apply(32'h1234_5678, 3'd0, 0, 1'b1, 2'd1, 1'b0);   // R5
        apply(32'h1234_5678, 3'd2, 0, 1'b0, 2'd0, 1'b1);   // R5
        apply(32'h0000_0001, 3'd4, 17, 1'b0, 2'd0, 1'b1);  // R6 amount ignored
        apply(32'hF000_0000, 3'd4, 0, 1'b1, 2'd3, 1'b1);   // R6 R10
        apply(32'hDEAD_BEEF, 3'd0, 32, 1'b1, 2'd1, 1'b1);  // R7 LSL 32
        apply(32'hDEAD_BEEF, 3'd3, 32, 1'b0, 2'd1, 1'b0);  // R7
        apply(32'hDEAD_BEEF, 3'd1, 33, 1'b1, 2'd0, 1'b1);  // R7
        apply(32'hDEAD_BEEF, 3'd6, 4, 1'b0, 2'd1, 1'b1);   // R7
        apply(32'hCAFE_0001, 3'd1, 1, 1'b0, 2'd2, 1'b1);   // R10

        // Constrained random
        for (int t = 0; t < 2000; t++) begin
            logic [2:0] k;
            int         n;
            k = ($urandom % 8 < 6) ? 3'($urandom % 5) : 3'($urandom % 8);
            case ($urandom % 4)
                0: n = 0;
                1: n = 31 + int'($urandom % 3);
                default: n = int'($urandom % 64);
            endcase
            apply($urandom, k, n, 1'($urandom), 2'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule